// File: doc/BRIEF.md
# Dual Down-Counter Timer with Interrupt Status

This block holds two independent 32-bit down-counters behind a small word-wide register port. Each counter has a reload register and a control word. The control word carries a two-bit command (load, hold or run) and a field that picks which of four incoming tick strobes advances the counter. The tick strobes are made elsewhere and arrive as single-cycle enables.

When a running counter reaches the end of its period, it reloads itself and sets its own sticky bit in a shared status register. Software clears status bits by writing ones to an acknowledge location. A mask register gates the status onto one level-sensitive interrupt output and onto a masked-status view. A free-running cycle counter can also be read through the same port. Only full-word accesses are accepted.

Top module: `dual_tmr_irq`

## Requirements
- R1: The word offsets are: counter 0 reload 0x00, count 0x04, control 0x08; counter 1 reload 0x10, count 0x14, control 0x18; cycle counter 0x38; mask 0x48; acknowledge 0x4C; raw status 0x50; masked status 0x54. Reload and mask registers read back the last value written (the mask keeps bits [1:0]).
- R2: Writing control with bits [1:0] = 0 copies the reload register into the counter and leaves the counter stopped.
- R3: Control command 1 stops the counter, which then ignores ticks. A control write with command 3 is dropped: the control readback (bits [4:2] source, [1:0] command) and the count do not change.
- R4: With command 2 the counter drops by one on each cycle in which its selected tick is high. Source values 4 to 7 in control bits [4:2] select tick_en[0] to tick_en[3]. Source values 0 to 3 select no tick, and the counter does not move.
- R5: A selected tick that arrives while the count is 0 or 1 reloads the counter from the reload register and sets status bit 0 (counter 0) or bit 1 (counter 1). A reload value of D >= 1 therefore gives one expiry every D ticks.
- R6: Status bits stay set until a write to the acknowledge location with a 1 in that bit position. If a set and an acknowledge of the same bit fall in one cycle, the set wins. The acknowledge location reads as zero.
- R7: Masked status equals raw status AND mask. irq_o is high exactly when masked status is nonzero, from the cycle after the status or mask register changes.
- R8: The cycle counter advances by one on every clock after reset.
- R9: An access with bus_size other than 2'b10 (word) raises bus_err in the same cycle. It writes nothing and reads zero.
- R10: Writes to unmapped offsets change no register. Reads from unmapped offsets return zero.
- R11: Synchronous reset clears both counters, their reload and control registers (both stopped), the raw status, the mask and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size, 2'b10 = word |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the strobe |
| bus_err | output | 1 | Illegal access size |
| tick_en | input | 4 | Tick strobes, one per clock source |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that tick strobes and bus accesses are clean synchronous levels that are sampled only at rising edges. They also assume that reset is held for at least one edge before any access, so the checks that follow reset start from a known state. The stimulus changes every input on the falling edge and returns the strobes to zero before the next access. The random part keeps both counters on hold while it varies the mask, so the status it checks against stays fixed and can be predicted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int N_CH     = 2;
    localparam int N_TICK   = 4;
    localparam int SRC_W    = 3;
    localparam int CH_STRIDE = 'h10;

    localparam int OFS_DIV    = 'h00;
    localparam int OFS_CNT    = 'h04;
    localparam int OFS_CTL    = 'h08;
    localparam int OFS_TIME   = 'h38;
    localparam int OFS_MASK   = 'h48;
    localparam int OFS_ACK    = 'h4C;
    localparam int OFS_RAW    = 'h50;
    localparam int OFS_MASKED = 'h54;

    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [1:0] {
        CMD_LOAD = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_RUN  = 2'd2,
        CMD_BAD  = 2'd3
    } tmr_cmd_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        tmr_cmd_e         cmd;
    } tmr_ctl_t;

    function automatic logic pick_tick(input logic [SRC_W-1:0] src,
                                       input logic [N_TICK-1:0] ticks);
        return src[SRC_W-1] ? ticks[src[SRC_W-2:0]] : 1'b0;
    endfunction

    function automatic logic [AW-1:0] ch_ofs(input int ch, input int base);
        return AW'(base + ch * CH_STRIDE);
    endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              div_we,
    input  logic              ctl_we,
    input  logic [DW-1:0]     wdata,
    input  logic [N_TICK-1:0] tick_en,
    output logic [DW-1:0]     div_q,
    output tmr_ctl_t          ctl_q,
    output logic [DW-1:0]     count_q,
    output logic              expire
);
    tmr_ctl_t ctl_new;
    logic     ctl_upd;
    logic     tick_sel;
    logic     advance;

    always_comb begin
        ctl_new  = tmr_ctl_t'(wdata[SRC_W+1:0]);
        ctl_upd  = ctl_we && (ctl_new.cmd != CMD_BAD);
        tick_sel = pick_tick(ctl_q.src, tick_en);
        advance  = (ctl_q.cmd == CMD_RUN) && tick_sel && !ctl_upd;
        expire   = advance && (count_q <= DW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            ctl_q   <= '0;
            count_q <= '0;
        end else begin
            if (div_we)
                div_q <= wdata;
            if (ctl_upd) begin
                ctl_q <= ctl_new;
                if (ctl_new.cmd == CMD_LOAD)
                    count_q <= div_q;
            end else if (advance) begin
                if (count_q <= DW'(1))
                    count_q <= div_q;
                else
                    count_q <= count_q - DW'(1);
            end
        end
    end

    // R3: a stopped counter ignores ticks
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cmd == CMD_HOLD && !ctl_we) |=> $stable(count_q));
    // R3: an illegal command leaves the control word alone
    p_bad_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && wdata[1:0] == 2'b11) |=> $stable(ctl_q));
    // R4: one step down per selected tick
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cmd == CMD_RUN && tick_sel && !ctl_we && count_q > DW'(1))
        |=> count_q == $past(count_q) - DW'(1));
    // R5: expiry reloads from the reload register
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        expire |=> count_q == $past(div_q));
endmodule

// File: rtl/tmr_status.sv
module tmr_status
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] expire,
    input  logic            mask_we,
    input  logic            ack_we,
    input  logic [N_CH-1:0] wbits,
    output logic [N_CH-1:0] raw_q,
    output logic [N_CH-1:0] mask_q,
    output logic            irq
);
    logic [N_CH-1:0] clr;

    always_comb begin
        clr = ack_we ? wbits : '0;
        irq = |(raw_q & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | expire;
            if (mask_we)
                mask_q <= wbits;
        end
    end

    // R6: a set is never lost, even against an acknowledge
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (|expire) |=> ((raw_q & $past(expire)) == $past(expire)));
    // R6: acknowledged bits clear when nothing sets them
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_we && expire == '0) |=> ((raw_q & $past(wbits)) == '0));
    // R11: state after reset
    p_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && mask_q == '0 && !irq));
endmodule

// File: rtl/dual_tmr_irq.sv
module dual_tmr_irq
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    input  logic [N_TICK-1:0] tick_en,
    output logic              irq_o
);
    logic            acc_ok, wr, rd;
    logic [DW-1:0]   time_q;
    logic [DW-1:0]   div_q   [N_CH];
    logic [DW-1:0]   count_q [N_CH];
    tmr_ctl_t        ctl_q   [N_CH];
    logic [N_CH-1:0] expire;
    logic [N_CH-1:0] raw_q, mask_q;
    logic            mask_we, ack_we;

    always_comb begin
        acc_ok  = bus_sel && (bus_size == SZ_WORD);
        bus_err = bus_sel && (bus_size != SZ_WORD);
        wr      = acc_ok && bus_we;
        rd      = acc_ok && !bus_we;
        mask_we = wr && (bus_addr == AW'(OFS_MASK));
        ack_we  = wr && (bus_addr == AW'(OFS_ACK));
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tmr_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .div_we  (wr && (bus_addr == ch_ofs(g, OFS_DIV))),
            .ctl_we  (wr && (bus_addr == ch_ofs(g, OFS_CTL))),
            .wdata   (bus_wdata),
            .tick_en (tick_en),
            .div_q   (div_q[g]),
            .ctl_q   (ctl_q[g]),
            .count_q (count_q[g]),
            .expire  (expire[g])
        );
    end

    tmr_status u_status (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wbits   (bus_wdata[N_CH-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) time_q <= '0;
        else     time_q <= time_q + DW'(1);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            for (int i = 0; i < N_CH; i++) begin
                if (bus_addr == ch_ofs(i, OFS_DIV)) bus_rdata = div_q[i];
                if (bus_addr == ch_ofs(i, OFS_CNT)) bus_rdata = count_q[i];
                if (bus_addr == ch_ofs(i, OFS_CTL)) bus_rdata = DW'(ctl_q[i]);
            end
            if (bus_addr == AW'(OFS_TIME))   bus_rdata = time_q;
            if (bus_addr == AW'(OFS_MASK))   bus_rdata = DW'(mask_q);
            if (bus_addr == AW'(OFS_RAW))    bus_rdata = DW'(raw_q);
            if (bus_addr == AW'(OFS_MASKED)) bus_rdata = DW'(raw_q & mask_q);
        end
    end

    // R8: cycle counter steps every clock
    p_time_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> time_q == $past(time_q) + DW'(1));
    // R9: a rejected access returns no data
    p_err_r9: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);
endmodule

// File: tb/dual_tmr_irq_bench.sv
module dual_tmr_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  tick_en = '0;
    logic        irq_o;

    int checks = 0, fails = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tmr_irq u_dual_tmr_irq (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .tick_en(tick_en),
        .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_masked(input logic [1:0] raw, input logic [1:0] m);
        return {30'd0, raw & m};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_size = 2'b10; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_size = 2'b10; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic tick(input logic [3:0] t);
        @(negedge clk);
        tick_en = t;
        @(negedge clk);
        tick_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, t0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        rd(8'h04, v); chk("R11 count0", v, 0);
        rd(8'h08, v); chk("R11 ctl0", v, 0);
        rd(8'h50, v); chk("R11 raw", v, 0);
        rd(8'h48, v); chk("R11 mask", v, 0);
        chk("R11 irq", irq_o, 0);

        // R1 / R2 load
        wr(8'h00, 32'd3);
        rd(8'h00, v); chk("R1 div0", v, 3);
        wr(8'h08, 32'h10);
        rd(8'h04, v); chk("R2 load", v, 3);
        tick(4'b0001);
        rd(8'h04, v); chk("R2 stopped after load", v, 3);
        // R4 run
        wr(8'h08, 32'h12);
        tick(4'b0001); rd(8'h04, v); chk("R4 step", v, 2);
        tick(4'b0010); rd(8'h04, v); chk("R4 other source", v, 2);
        tick(4'b0001); rd(8'h04, v); chk("R4 step2", v, 1);
        // R5 expiry
        tick(4'b0001); rd(8'h04, v); chk("R5 reload", v, 3);
        rd(8'h50, v); chk("R5 status bit0", v, 1);
        chk("R7 irq masked off", irq_o, 0);

        // R3 hold (stops before next expiry)
        wr(8'h08, 32'h11);
        // R7 random mask with frozen status
        for (int i = 0; i < 20; i++) begin
            logic [31:0] m;
            m = $urandom;
            wr(8'h48, m);
            rd(8'h48, v); chk("R1 mask readback", v, {30'd0, m[1:0]});
            rd(8'h54, v); chk("R7 masked", v, exp_masked(2'b01, m[1:0]));
            chk("R7 irq", irq_o, |exp_masked(2'b01, m[1:0]));
        end
        for (int i = 0; i < 10; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr(8'h10, r);
            rd(8'h10, v); chk("R1 div1 random", v, r);
        end
        wr(8'h48, 32'h1);
        chk("R7 irq on", irq_o, 1);
        repeat (5) @(negedge clk);
        rd(8'h50, v); chk("R6 sticky", v, 1);
        wr(8'h4C, 32'h1);
        chk("R7 irq off after ack", irq_o, 0);
        rd(8'h50, v); chk("R6 ack clears", v, 0);
        rd(8'h4C, v); chk("R6 ack reads zero", v, 0);

        tick(4'b0001); rd(8'h04, v); chk("R3 hold", v, 3);
        wr(8'h08, 32'h13);
        rd(8'h08, v); chk("R3 bad cmd ctl", v, 32'h11);
        tick(4'b0001); rd(8'h04, v); chk("R3 bad cmd count", v, 3);

        // R6 set wins
        wr(8'h00, 32'd1);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        @(negedge clk);
        tick_en = 4'b0001;
        bus_sel = 1; bus_we = 1; bus_size = 2'b10; bus_addr = 8'h4C; bus_wdata = 32'h1;
        @(negedge clk);
        tick_en = 0; bus_sel = 0; bus_we = 0;
        rd(8'h50, v); chk("R6 set wins", v, 1);
        wr(8'h08, 32'h11);
        wr(8'h4C, 32'h1);

        // R4 / R5 timer1 on source 7
        wr(8'h10, 32'd2);
        wr(8'h18, 32'h1C);
        wr(8'h18, 32'h1E);
        tick(4'b1000); rd(8'h14, v); chk("R4 src7 step", v, 1);
        tick(4'b1000); rd(8'h14, v); chk("R5 timer1 reload", v, 2);
        rd(8'h50, v); chk("R5 status bit1", v, 2);
        wr(8'h48, 32'h2);
        rd(8'h54, v); chk("R7 masked bit1", v, 2);
        chk("R7 irq bit1", irq_o, 1);
        wr(8'h18, 32'h02);
        tick(4'b1111); rd(8'h14, v); chk("R4 source0 no count", v, 2);

        // R8 time
        rd(8'h38, t0); rd(8'h38, v); chk("R8 step", v - t0, 1);
        repeat (10) @(negedge clk);
        rd(8'h38, t0); chk("R8 gap", t0 - v, 11);

        // R9 size error
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_size = 2'b01; bus_addr = 8'h00; bus_wdata = 32'hAA;
        #1 chk("R9 err on write", bus_err, 1);
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_size = 2'b10;
        rd(8'h00, v); chk("R9 write dropped", v, 1);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_size = 2'b00; bus_addr = 8'h00;
        #1 chk("R9 err on read", bus_err, 1);
        chk("R9 read zero", bus_rdata, 0);
        bus_sel = 0; bus_size = 2'b10;

        // R10 unmapped
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h5);
        rd(8'h20, v); chk("R10 read zero", v, 0);
        rd(8'h00, v); chk("R10 div0 untouched", v, 1);
        rd(8'h10, v); chk("R10 div1 untouched", v, 2);
        rd(8'h48, v); chk("R10 mask untouched", v, 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule